// File: doc/BRIEF.md
# Periodic Sensor Sampling Averager

This block paces temperature measurements for up to three sensor channels and turns their raw 12-bit converter codes into per-channel results. A free-running period counter starts a measurement round every 4096 × (PER + 1) clocks. Within a round, every enabled channel gets one conversion, in ascending channel order. Each conversion holds an acquire window of (N + 1) clocks. The block then waits for the converter to return a code.

The codes pass either straight to the channel's result register or through an averaging filter. The filter sums a power-of-two number of samples per channel and stores the truncated mean. Each result update sets a sticky data-ready bit for that channel, which the surrounding logic clears with a per-channel clear pulse. The analog converter is not part of the block: it is seen as a valid strobe carrying a 12-bit code.

Top module: `sensorRoundAverager`

## Requirements
- R1: After reset every result register reads 0, all data-ready bits read 0 and `acqActive` is low.
- R2: A measurement round starts every 4096 × (`periodSel` + 1) clock cycles. The period counter restarts at each round start, so the first acquire of successive rounds begins exactly that many cycles apart.
- R3: Each conversion raises `acqActive` for exactly `acqTime` + 1 consecutive cycles, with `acqChan` giving the channel being converted.
- R4: `chanEnable` bit c enables channel c. Within a round, enabled channels are converted in ascending index order. Disabled channels are skipped and their result and data-ready bit are left unchanged.
- R5: With `filterCode` bit 2 at 0, every accepted sample is written unchanged into its channel's result.
- R6: With `filterCode` bit 2 at 1, a low field `filterCode[1:0]` of 1 averages 4 samples and any other value averages 8. The result is the sum shifted right by 2 or 3 with no rounding. It updates only once the full count has been collected. The 15-bit sum never overflows, even with all codes at 4095.
- R7: Data-ready bit c is set in the same cycle that result c updates. It stays set until `readyClear[c]` is pulsed, and a set in the same cycle wins over a clear.
- R8: A `sampleValid` strobe that arrives while no conversion is waiting for its code (for example during the acquire window) is ignored.
- R9: Result c is presented on `chanData[12*c +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodSel | input | 8 | Round period multiplier PER |
| acqTime | input | 16 | Acquire window length minus one |
| chanEnable | input | 3 | Per-channel enable |
| filterCode | input | 3 | Bit 2 averaging on, bits 1:0 sample-count select |
| readyClear | input | 3 | Per-channel data-ready clear pulse |
| sampleValid | input | 1 | Converter code valid |
| sampleCode | input | 12 | Converter code |
| acqActive | output | 1 | Acquire window in progress |
| acqChan | output | 2 | Channel of the current conversion |
| chanData | output | 36 | Per-channel results, channel c at bits 12c+11:12c |
| dataReady | output | 3 | Sticky per-channel data-ready |

## Verification
An accepted code reaches its result and data-ready bit on the clock edge where `sampleValid` is seen in the waiting state. A round therefore completes about 10 cycles per channel after its start. Each round start lands on a fixed multiple of 4096 × (PER + 1) cycles after reset. The bench sets each round's codes between rounds and reads results 100 cycles after the expected round start. It times acquire windows and round spacing by counting falling-edge samples of `acqActive`. A clear pulse is applied for one cycle and its effect is read on the next falling edge.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int CHAN_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_WAIT
  } sra_state_e;

  typedef struct packed {
    logic              take;
    logic [CHAN_W-1:0] chan;
  } sra_strobe_t;
endpackage

// File: rtl/sraControl.sv
module sraControl
  import sra_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int PER_W     = 8,
  parameter int ACQ_W     = 16,
  parameter int UNIT_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PER_W-1:0]  periodSel,
  input  logic [ACQ_W-1:0]  acqTime,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic              sampleValid,
  output sra_strobe_t       strobe,
  output logic              acqActive,
  output logic [CHAN_W-1:0] acqChan
);
  localparam int CNT_W = PER_W + UNIT_LOG2 + 1;

  sra_state_e        state;
  logic [CNT_W-1:0]  perCnt;
  logic [CNT_W-1:0]  periodLen;
  logic              roundStart;
  logic [ACQ_W-1:0]  acqCnt;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] pendAfter;
  logic [NUM_CH-1:0] srcMask;
  logic [CHAN_W-1:0] cur;
  logic [CHAN_W-1:0] pick;

  // R2: period counter, restarts at every round start
  assign periodLen  = (CNT_W'(periodSel) + CNT_W'(1)) << UNIT_LOG2;
  assign roundStart = (perCnt == periodLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) perCnt <= '0;
    else if (roundStart) perCnt <= '0;
    else perCnt <= perCnt + CNT_W'(1);
  end

  // R4: lowest pending channel goes next
  assign pendAfter = pend & ~(NUM_CH'(1) << cur);
  assign srcMask   = (state == ST_IDLE) ? chanEnable : pendAfter;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (srcMask[i]) pick = CHAN_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      acqCnt <= '0;
      pend   <= '0;
      cur    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (roundStart && (|chanEnable)) begin
            pend   <= chanEnable;
            cur    <= pick;
            acqCnt <= '0;
            state  <= ST_ACQ;
          end
        end
        ST_ACQ: begin
          // R3: window of acqTime+1 cycles
          if (acqCnt == acqTime) state <= ST_WAIT;
          else acqCnt <= acqCnt + ACQ_W'(1);
        end
        ST_WAIT: begin
          if (sampleValid) begin
            pend <= pendAfter;
            if (|pendAfter) begin
              cur    <= pick;
              acqCnt <= '0;
              state  <= ST_ACQ;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: only a waiting conversion accepts a code
  assign strobe.take = (state == ST_WAIT) && sampleValid;
  assign strobe.chan = cur;
  assign acqActive   = (state == ST_ACQ);
  assign acqChan     = cur;
endmodule

// File: rtl/sraDatapath.sv
module sraDatapath
  import sra_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 15
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sra_strobe_t                  strobe,
  input  logic [SAMPLE_W-1:0]          sampleCode,
  input  logic [2:0]                   filterCode,
  input  logic [NUM_CH-1:0]            readyClear,
  output logic [NUM_CH*SAMPLE_W-1:0]   chanData,
  output logic [NUM_CH-1:0]            dataReady
);
  logic       avgOn;
  logic       avgFour;
  logic [2:0] lastIdx;

  // R5/R6: filter code decode
  assign avgOn   = filterCode[2];
  assign avgFour = (filterCode[1:0] == 2'd1);
  assign lastIdx = avgFour ? 3'd3 : 3'd7;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [ACC_W-1:0]    acc;
    logic [ACC_W-1:0]    sumNext;
    logic [ACC_W-1:0]    meanWide;
    logic [2:0]          cnt;
    logic [SAMPLE_W-1:0] dataQ;
    logic                rdyQ;
    logic                hit;
    logic                lastOne;
    logic                update;

    assign hit      = strobe.take && (strobe.chan == CHAN_W'(c));
    assign sumNext  = acc + ACC_W'(sampleCode);
    assign meanWide = avgFour ? (sumNext >> 2) : (sumNext >> 3);
    assign lastOne  = (cnt == lastIdx);
    assign update   = hit && (!avgOn || lastOne);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc   <= '0;
        cnt   <= '0;
        dataQ <= '0;
      end else if (hit) begin
        if (!avgOn) begin
          dataQ <= sampleCode;
        end else if (lastOne) begin
          dataQ <= meanWide[SAMPLE_W-1:0];
          acc   <= '0;
          cnt   <= '0;
        end else begin
          acc <= sumNext;
          cnt <= cnt + 3'd1;
        end
      end
    end

    // R7: sticky ready, set wins over clear
    always_ff @(posedge clk) begin
      if (!rstN) rdyQ <= 1'b0;
      else if (update) rdyQ <= 1'b1;
      else if (readyClear[c]) rdyQ <= 1'b0;
    end

    assign chanData[c*SAMPLE_W +: SAMPLE_W] = dataQ;
    assign dataReady[c] = rdyQ;
  end
endmodule

// File: rtl/sensorRoundAverager.sv
module sensorRoundAverager
  import sra_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int SAMPLE_W  = 12,
  parameter int PER_W     = 8,
  parameter int ACQ_W     = 16,
  parameter int UNIT_LOG2 = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [PER_W-1:0]           periodSel,
  input  logic [ACQ_W-1:0]           acqTime,
  input  logic [NUM_CH-1:0]          chanEnable,
  input  logic [2:0]                 filterCode,
  input  logic [NUM_CH-1:0]          readyClear,
  input  logic                       sampleValid,
  input  logic [SAMPLE_W-1:0]        sampleCode,
  output logic                       acqActive,
  output logic [CHAN_W-1:0]          acqChan,
  output logic [NUM_CH*SAMPLE_W-1:0] chanData,
  output logic [NUM_CH-1:0]          dataReady
);
  localparam int ACC_W = SAMPLE_W + 3;

  sra_strobe_t strobe;

  sraControl #(
    .NUM_CH(NUM_CH), .PER_W(PER_W), .ACQ_W(ACQ_W), .UNIT_LOG2(UNIT_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .periodSel(periodSel), .acqTime(acqTime),
    .chanEnable(chanEnable), .sampleValid(sampleValid), .strobe(strobe),
    .acqActive(acqActive), .acqChan(acqChan)
  );

  sraDatapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleCode(sampleCode),
    .filterCode(filterCode), .readyClear(readyClear),
    .chanData(chanData), .dataReady(dataReady)
  );
endmodule

// File: rtl/sraChecker.sv
module sraChecker #(
  parameter int NUM_CH   = 3,
  parameter int SAMPLE_W = 12,
  parameter int ACQ_W    = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       acqActive,
  input logic [ACQ_W-1:0]           acqTime,
  input logic                       sampleValid,
  input logic [NUM_CH*SAMPLE_W-1:0] chanData,
  input logic [NUM_CH-1:0]          dataReady,
  input logic [NUM_CH-1:0]          readyClear
);
  logic [ACQ_W:0] acqLen;

  always_ff @(posedge clk) begin
    if (!rstN) acqLen <= '0;
    else if (acqActive) acqLen <= acqLen + 1'b1;
    else acqLen <= '0;
  end

  a_r3_acq_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(acqActive) |-> (acqLen == {1'b0, acqTime} + 1'b1));

  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|(dataReady & ~readyClear)) |=>
      ((dataReady & $past(dataReady & ~readyClear)) == $past(dataReady & ~readyClear)));

  a_r8_ignore_during_acq: assert property (@(posedge clk) disable iff (!rstN)
    (acqActive && sampleValid) |=> $stable(chanData));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_upd
    a_r7_ready_on_update: assert property (@(posedge clk) disable iff (!rstN)
      (chanData[c*SAMPLE_W +: SAMPLE_W] != $past(chanData[c*SAMPLE_W +: SAMPLE_W]))
        |-> dataReady[c]);
  end
endmodule

bind sensorRoundAverager sraChecker #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .ACQ_W(ACQ_W)
) u_chk (
  .clk(clk), .rstN(rstN), .acqActive(acqActive), .acqTime(acqTime),
  .sampleValid(sampleValid), .chanData(chanData), .dataReady(dataReady),
  .readyClear(readyClear)
);

// File: tb/sensorRoundAverager_test.sv
module sensorRoundAverager_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  periodSel = '0;
  logic [15:0] acqTime = 16'd5;
  logic [2:0]  chanEnable = 3'b111;
  logic [2:0]  filterCode = 3'b000;
  logic [2:0]  readyClear = '0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleCode = '0;
  logic        acqActive;
  logic [1:0]  acqChan;
  logic [35:0] chanData;
  logic [2:0]  dataReady;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  // converter model state
  logic [11:0] nextCode [3];
  logic        noise = 1'b0;
  logic        prevAcq = 1'b0;
  int          logCnt = 0;
  int          orderLog [16];
  int          riseT [16];
  int          acqLenCnt = 0;
  int          lastAcqLen = 0;
  int          delayCnt = 0;
  int          curChan = 0;

  sensorRoundAverager uut (
    .clk(clk), .rstN(rstN), .periodSel(periodSel), .acqTime(acqTime),
    .chanEnable(chanEnable), .filterCode(filterCode), .readyClear(readyClear),
    .sampleValid(sampleValid), .sampleCode(sampleCode), .acqActive(acqActive),
    .acqChan(acqChan), .chanData(chanData), .dataReady(dataReady)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  initial begin
    forever begin
      @(negedge clk);
      sampleValid = 1'b0;
      if (acqActive) begin
        if (!prevAcq) begin
          if (logCnt < 16) begin
            orderLog[logCnt] = int'(acqChan);
            riseT[logCnt] = cycle;
          end
          logCnt++;
          curChan = int'(acqChan);
          acqLenCnt = 0;
        end
        acqLenCnt++;
        if (noise && acqLenCnt == 2) begin
          sampleValid = 1'b1;
          sampleCode = 12'hABC;
        end
      end else if (prevAcq) begin
        lastAcqLen = acqLenCnt;
        delayCnt = 2;
      end else if (delayCnt > 0) begin
        delayCnt--;
        if (delayCnt == 0) begin
          sampleValid = 1'b1;
          sampleCode = nextCode[curChan];
        end
      end
      prevAcq = acqActive;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] dataOf(input int c);
    return chanData[c*12 +: 12];
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    logCnt = 0;
    rstN = 1'b1;
  endtask

  task automatic setCodes(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c);
    nextCode[0] = a;
    nextCode[1] = b;
    nextCode[2] = c;
  endtask

  task automatic waitRound(input bit first);
    int len;
    len = 4096 * (int'(periodSel) + 1);
    repeat (first ? len + 100 : len) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check("R1 data", {28'd0, chanData[35:32]} | chanData[31:0], 0);
    check("R1 ready", {29'd0, dataReady}, 0);
    check("R1 acqActive", {31'd0, acqActive}, 0);
  endtask

  task automatic testRawAll();
    periodSel = 0; acqTime = 16'd5; chanEnable = 3'b111; filterCode = 3'b000;
    doReset();
    setCodes(12'd300, 12'd1234, 12'd4095);
    waitRound(1);
    check("R4 conversions", logCnt, 3);
    check("R4 order0", orderLog[0], 0);
    check("R4 order1", orderLog[1], 1);
    check("R4 order2", orderLog[2], 2);
    check("R3 acquire length", lastAcqLen, 6);
    check("R5 ch0", {20'd0, dataOf(0)}, 300);
    check("R5 ch1", {20'd0, dataOf(1)}, 1234);
    check("R9 ch2", {20'd0, dataOf(2)}, 4095);
    check("R7 ready set", {29'd0, dataReady}, 3'b111);
    readyClear = 3'b010;
    @(negedge clk);
    readyClear = 3'b000;
    check("R7 clear one", {29'd0, dataReady}, 3'b101);
    check("R7 data kept", {20'd0, dataOf(1)}, 1234);
    readyClear = 3'b111;
    @(negedge clk);
    readyClear = 3'b000;
    check("R7 clear all", {29'd0, dataReady}, 0);
  endtask

  task automatic testMask();
    periodSel = 0; acqTime = 16'd3; chanEnable = 3'b101; filterCode = 3'b000;
    doReset();
    setCodes(12'd11, 12'd22, 12'd33);
    waitRound(1);
    check("R4 masked conversions", logCnt, 2);
    check("R4 masked order0", orderLog[0], 0);
    check("R4 masked order1", orderLog[1], 2);
    check("R3 acquire length 4", lastAcqLen, 4);
    check("R4 skipped data", {20'd0, dataOf(1)}, 0);
    check("R4 masked ready", {29'd0, dataReady}, 3'b101);
    check("R4 ch2", {20'd0, dataOf(2)}, 33);
  endtask

  task automatic testAvg4();
    logic [11:0] c0 [4];
    logic [11:0] c2 [4];
    c0 = '{12'd100, 12'd101, 12'd102, 12'd104};
    c2 = '{12'd0, 12'd1, 12'd2, 12'd3};
    periodSel = 0; acqTime = 16'd5; chanEnable = 3'b111; filterCode = 3'b101;
    doReset();
    for (int r = 0; r < 4; r++) begin
      setCodes(c0[r], 12'd4095, c2[r]);
      waitRound(r == 0);
      if (r == 2) begin
        check("R6 avg4 no early update", {20'd0, dataOf(0)}, 0);
        check("R6 avg4 no early ready", {29'd0, dataReady}, 0);
      end
    end
    check("R6 avg4 ch0", {20'd0, dataOf(0)}, 101);
    check("R6 avg4 ch1 full scale", {20'd0, dataOf(1)}, 4095);
    check("R6 avg4 ch2 truncated", {20'd0, dataOf(2)}, 1);
    check("R7 avg4 ready", {29'd0, dataReady}, 3'b111);
  endtask

  task automatic testAvg8();
    periodSel = 0; acqTime = 16'd2; chanEnable = 3'b111; filterCode = 3'b110;
    doReset();
    for (int r = 0; r < 8; r++) begin
      setCodes(12'(10 + r), 12'd4095, (r == 0) ? 12'd1 : 12'd0);
      waitRound(r == 0);
      if (r == 4) check("R6 avg8 no update after 5", {20'd0, dataOf(0)}, 0);
    end
    check("R6 avg8 ch0", {20'd0, dataOf(0)}, 13);
    check("R6 avg8 ch1 no overflow", {20'd0, dataOf(1)}, 4095);
    check("R6 avg8 ch2 floor", {20'd0, dataOf(2)}, 0);
  endtask

  task automatic testNoise();
    periodSel = 0; acqTime = 16'd5; chanEnable = 3'b111; filterCode = 3'b000;
    doReset();
    noise = 1'b1;
    setCodes(12'd7, 12'd8, 12'd9);
    waitRound(1);
    noise = 1'b0;
    check("R8 ch0 ignores stray", {20'd0, dataOf(0)}, 7);
    check("R8 ch1 ignores stray", {20'd0, dataOf(1)}, 8);
    check("R8 ch2 ignores stray", {20'd0, dataOf(2)}, 9);
  endtask

  task automatic testPeriod();
    periodSel = 8'd1; acqTime = 16'd1; chanEnable = 3'b001; filterCode = 3'b000;
    doReset();
    setCodes(12'd5, 12'd0, 12'd0);
    waitRound(1);
    waitRound(0);
    waitRound(0);
    check("R2 rounds", logCnt, 3);
    check("R2 spacing a", riseT[1] - riseT[0], 8192);
    check("R2 spacing b", riseT[2] - riseT[1], 8192);
  endtask

  initial begin
    testReset();
    testRawAll();
    testMask();
    testAvg4();
    testAvg8();
    testNoise();
    testPeriod();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule